// File: doc/BRIEF.md
# Control Register File with Banked Stack Access

This block holds the processor's control registers that software reaches through a 12-bit register code, as used by a move-to/from-control-register operation. The registers are the two address-space selectors, the cache control and cache address registers, the translation control, transparent-window and access-control registers, the vector base, the translation status word and the two root pointers. A read returns data in the same cycle that the code is presented. A write with the strobe asserted takes effect on the next clock edge.

Three codes reach the stack pointers indirectly: user, master and interrupt. Each of these pointers lives in one of two places. If the current mode makes it the active stack, it is the live A7 held by the status block. Otherwise it is a banked copy held here. The supervisor bit, the master bit and the live A7 arrive as inputs. A write that lands on the live A7 does not touch local storage. Instead it raises a one-cycle strobe with the data so that the status block can update A7. Any code that is not decoded reads as zero, and a write to it is dropped. The active-low reset is asserted asynchronously and released synchronously after two clock edges.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset, every stored register and every banked stack copy reads as zero.
- R2: Codes 0x002 to 0x00B each store a full 32-bit word written with wr_en_i, and reading the same code returns it.
- R3: Codes 0x000 and 0x001 keep only bits [2:0] of the written word, and bits [31:3] read back as zero.
- R4: Codes 0x801, 0x802, 0x805, 0x806 and 0x807 each store a full 32-bit word.
- R5: Code 0x800 (user stack) addresses the live A7 when sup_i is 0 and the user bank copy when sup_i is 1.
- R6: Code 0x803 (master stack) addresses the live A7 only when sup_i and master_i are both 1, and its bank copy otherwise.
- R7: Code 0x804 (interrupt stack) addresses the live A7 only when sup_i is 1 and master_i is 0, and its bank copy otherwise.
- R8: A write to a stack code that addresses the live A7 asserts a7_we_o in that same cycle with a7_wdata_o equal to wr_data_i, and leaves the bank copy unchanged. A write to a bank copy leaves a7_we_o low.
- R9: A code outside the decoded set reads as zero. A write to such a code changes no register and does not assert a7_we_o.
- R10: rd_data_o follows the code combinationally in the cycle it is presented. A written value is visible from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 12 | Control register code |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for code_i |
| sup_i | input | 1 | Supervisor mode bit from the status block |
| master_i | input | 1 | Master stack select bit from the status block |
| a7_i | input | 32 | Live A7 value |
| a7_we_o | output | 1 | Request to write the live A7 |
| a7_wdata_o | output | 32 | Data for the live A7 write |

## Verification
The hardest situation to reach is a stack code whose target changes with the mode bits alone, with no write in between. One code then shows the live A7 in one cycle and a stale bank copy in the next. The stimulus gives each bank copy a distinct value while that pointer is inactive. It then drives a different live A7 value and steps through all four supervisor/master combinations, reading all three stack codes in each one. This covers the user-mode-with-master-set case, where the master bank must still be chosen. Writes to undecoded codes near the decoded ranges are followed by a full readback, which shows that they altered nothing.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int CODE_W   = 12;
  localparam int DATA_W   = 32;
  localparam int LO_N     = 12;        // low-range codes 0x000..LO_N-1
  localparam int HI_PLAIN = 5;         // plain registers in the high range
  localparam int PLAIN_N  = LO_N + HI_PLAIN;
  localparam int IDX_W    = $clog2(PLAIN_N);
  localparam int NARROW_N = 2;         // leading slots with a narrow width
  localparam int NARROW_W = 3;

  typedef enum logic [1:0] {
    STK_USER   = 2'd0,
    STK_MASTER = 2'd1,
    STK_INTR   = 2'd2
  } stk_sel_e;

  typedef struct packed {
    logic            plain_hit;
    logic [IDX_W-1:0] plain_idx;
    logic            stk_hit;
    stk_sel_e        stk_sel;
  } dec_t;
endpackage

// File: rtl/ctlreg_rst_sync.sv
module ctlreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output dec_t              dec_o
);
  logic lo_range;
  logic hi_range;

  // Low range: upper bits zero and the offset below LO_N.
  assign lo_range = (code_i < CODE_W'(LO_N));
  // High range: top bit set, everything between top bit and bit 3 clear.
  assign hi_range = code_i[CODE_W-1] && (code_i[CODE_W-2:3] == '0);

  always_comb begin
    dec_o           = '0;
    dec_o.stk_sel   = STK_USER;
    if (lo_range) begin
      dec_o.plain_hit = 1'b1;
      dec_o.plain_idx = IDX_W'(code_i);
    end else if (hi_range) begin
      unique case (code_i[2:0])
        3'd0: begin dec_o.stk_hit = 1'b1; dec_o.stk_sel = STK_USER;   end
        3'd3: begin dec_o.stk_hit = 1'b1; dec_o.stk_sel = STK_MASTER; end
        3'd4: begin dec_o.stk_hit = 1'b1; dec_o.stk_sel = STK_INTR;   end
        3'd1: begin dec_o.plain_hit = 1'b1; dec_o.plain_idx = IDX_W'(LO_N + 0); end
        3'd2: begin dec_o.plain_hit = 1'b1; dec_o.plain_idx = IDX_W'(LO_N + 1); end
        3'd5: begin dec_o.plain_hit = 1'b1; dec_o.plain_idx = IDX_W'(LO_N + 2); end
        3'd6: begin dec_o.plain_hit = 1'b1; dec_o.plain_idx = IDX_W'(LO_N + 3); end
        default: begin dec_o.plain_hit = 1'b1; dec_o.plain_idx = IDX_W'(LO_N + 4); end
      endcase
    end
  end
endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
  import ctlreg_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int N   = PLAIN_N,
  parameter int NN  = NARROW_N,
  parameter int NW  = NARROW_W,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] slot_rd [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic en;
    assign en = we_i && (idx_i == IW'(g));
    if (g < NN) begin : g_narrow
      logic [NW-1:0] q;
      logic [NW-1:0] d;
      always_comb d = en ? wdata_i[NW-1:0] : q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
      end
      assign slot_rd[g] = {{(DW-NW){1'b0}}, q};
    end else begin : g_wide
      logic [DW-1:0] q;
      logic [DW-1:0] d;
      always_comb d = en ? wdata_i : q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
      end
      assign slot_rd[g] = q;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++) begin
      if (idx_i == IW'(i)) rdata_o = slot_rd[i];
    end
  end
endmodule

// File: rtl/ctlreg_stkbank.sv
module ctlreg_stkbank
  import ctlreg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  stk_sel_e      sel_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sup_i,
  input  logic          master_i,
  input  logic [DW-1:0] a7_i,
  output logic [DW-1:0] rdata_o,
  output logic          a7_we_o,
  output logic [DW-1:0] a7_wdata_o
);
  localparam int BANKS = 3;

  logic [DW-1:0] bank_q [BANKS];
  logic [DW-1:0] bank_d [BANKS];
  logic [BANKS-1:0] active;   // which pointer is the live A7 now
  logic             live;
  logic [1:0]       bidx;

  always_comb begin
    active[STK_USER]   = !sup_i;
    active[STK_MASTER] = sup_i && master_i;
    active[STK_INTR]   = sup_i && !master_i;
  end

  assign bidx = sel_i;
  assign live = hit_i && active[bidx];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic en;
    assign en = hit_i && we_i && !live && (bidx == 2'(b));
    always_comb bank_d[b] = en ? wdata_i : bank_q[b];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank_q[b] <= '0;
      else         bank_q[b] <= bank_d[b];
    end
  end

  always_comb begin
    if (!hit_i)     rdata_o = '0;
    else if (live)  rdata_o = a7_i;
    else            rdata_o = bank_q[bidx];
  end

  assign a7_we_o    = live && we_i;
  assign a7_wdata_o = wdata_i;
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              sup_i,
  input  logic              master_i,
  input  logic [DATA_W-1:0] a7_i,
  output logic              a7_we_o,
  output logic [DATA_W-1:0] a7_wdata_o
);
  logic              rst_n_sync;
  dec_t              dec;
  logic [DATA_W-1:0] plain_rd;
  logic [DATA_W-1:0] stk_rd;

  ctlreg_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_sync)
  );

  ctlreg_decode u_dec (
    .code_i(code_i),
    .dec_o (dec)
  );

  ctlreg_store #(
    .DW(DATA_W), .N(PLAIN_N), .NN(NARROW_N), .NW(NARROW_W)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .we_i   (wr_en_i && dec.plain_hit),
    .idx_i  (dec.plain_idx),
    .wdata_i(wr_data_i),
    .rdata_o(plain_rd)
  );

  ctlreg_stkbank #(.DW(DATA_W)) u_stk (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .hit_i     (dec.stk_hit),
    .sel_i     (dec.stk_sel),
    .we_i      (wr_en_i),
    .wdata_i   (wr_data_i),
    .sup_i     (sup_i),
    .master_i  (master_i),
    .a7_i      (a7_i),
    .rdata_o   (stk_rd),
    .a7_we_o   (a7_we_o),
    .a7_wdata_o(a7_wdata_o)
  );

  always_comb begin
    if (dec.plain_hit)    rd_data_o = plain_rd;
    else if (dec.stk_hit) rd_data_o = stk_rd;
    else                  rd_data_o = '0;
  end
endmodule

// File: rtl/ctlreg_chk.sv
module ctlreg_chk
  import ctlreg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              sup_i,
  input logic              master_i,
  input logic [DATA_W-1:0] a7_i,
  input logic              a7_we_o,
  input logic [DATA_W-1:0] a7_wdata_o
);
  logic known;
  assign known = (code_i <= 12'h00B) || ((code_i >= 12'h800) && (code_i <= 12'h807));

  a_r9_unknown_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> rd_data_o == '0);
  a_r9_unknown_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> !a7_we_o);
  a_r3_narrow_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i <= 12'h001) |-> rd_data_o[DATA_W-1:3] == '0);
  a_r8_strobe_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a7_we_o |-> (wr_en_i && a7_wdata_o == wr_data_i));
  a_r5_user_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 12'h800 && !sup_i) |-> rd_data_o == a7_i);
  a_r6_master_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 12'h803 && sup_i && master_i) |-> rd_data_o == a7_i);
  a_r7_intr_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 12'h804 && sup_i && !master_i) |-> rd_data_o == a7_i);
  a_r8_bank_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && code_i == 12'h800 && sup_i) |-> !a7_we_o);
endmodule

bind ctlreg_bank ctlreg_chk u_chk (.*);

// File: tb/sim_ctlreg_bank.sv
`timescale 1ns/1ps
module sim_ctlreg_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] code;
  logic        we;
  logic [31:0] wd;
  logic [31:0] rd;
  logic        sup, mst;
  logic [31:0] a7;
  logic        a7_we;
  logic [31:0] a7_wd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctlreg_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd), .sup_i(sup), .master_i(master_i_w), .a7_i(a7),
    .a7_we_o(a7_we), .a7_wdata_o(a7_wd)
  );
  logic master_i_w;
  assign master_i_w = mst;

  typedef struct {
    logic [31:0] exp_rd;
    logic        exp_we;
    logic [31:0] exp_wd;
    string       tag;
  } item_t;
  item_t q[$];

  logic [31:0] m_plain [int];
  logic [31:0] m_usr, m_mst, m_int;

  task automatic step(input logic [11:0] c, input logic w, input logic [31:0] d,
                      input logic s, input logic m, input logic [31:0] live, input string tag);
    item_t it;
    logic  lv;
    @(negedge clk); #1;
    code = c; we = w; wd = d; sup = s; mst = m; a7 = live;
    it.tag = tag; it.exp_we = 1'b0; it.exp_wd = d; it.exp_rd = 32'h0;
    lv = 1'b0;
    if (m_plain.exists(int'(c))) it.exp_rd = m_plain[int'(c)];
    else if (c == 12'h800) begin lv = !s;      it.exp_rd = lv ? live : m_usr; end
    else if (c == 12'h803) begin lv = s && m;  it.exp_rd = lv ? live : m_mst; end
    else if (c == 12'h804) begin lv = s && !m; it.exp_rd = lv ? live : m_int; end
    it.exp_we = w && lv;
    q.push_back(it);
    if (w) begin
      if (m_plain.exists(int'(c))) m_plain[int'(c)] = (c < 12'h002) ? (d & 32'h7) : d;
      else if (!lv && c == 12'h800) m_usr = d;
      else if (!lv && c == 12'h803) m_mst = d;
      else if (!lv && c == 12'h804) m_int = d;
    end
  endtask

  // monitor: compare in the same cycle, away from the clock edge
  initial forever begin
    @(negedge clk); #3;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rd !== it.exp_rd || a7_we !== it.exp_we || (it.exp_we && a7_wd !== it.exp_wd)) begin
        errors++;
        $display("FAIL %s: rd=%h we=%b wd=%h expected rd=%h we=%b wd=%h",
                 it.tag, rd, a7_we, a7_wd, it.exp_rd, it.exp_we, it.exp_wd);
      end
    end
  end

  task automatic read_all(input string tag);
    for (int i = 0; i < 12; i++) step(12'(i), 0, 0, 1, 0, 32'hDEAD0000, tag);
    foreach (m_plain[k]) if (k >= 12'h800) step(12'(k), 0, 0, 1, 0, 32'hDEAD0000, tag);
    step(12'h800, 0, 0, 1, 0, 32'hDEAD0001, tag);
    step(12'h803, 0, 0, 1, 0, 32'hDEAD0002, tag);
    step(12'h804, 0, 0, 1, 1, 32'hDEAD0003, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 12; i++) m_plain[i] = 0;
    m_plain[12'h801] = 0; m_plain[12'h802] = 0; m_plain[12'h805] = 0;
    m_plain[12'h806] = 0; m_plain[12'h807] = 0;
    m_usr = 0; m_mst = 0; m_int = 0;
    rst_n = 0; code = 0; we = 0; wd = 0; sup = 1; mst = 0; a7 = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset state
    read_all("R1 reset");

    // R2 / R3: low range, narrow selectors
    for (int i = 0; i < 12; i++)
      step(12'(i), 1, 32'hC3A50000 ^ (32'h01010101 * i) ^ 32'hFFFF_FFF8 * (i & 1), 1, 0, 0,
           (i < 2) ? "R3 narrow write" : "R2 write");
    for (int i = 0; i < 12; i++)
      step(12'(i), 0, 0, 1, 0, 0, (i < 2) ? "R3 narrow read" : "R10 R2 read");
    step(12'h000, 1, 32'hFFFF_FFFF, 1, 0, 0, "R3 all ones");
    step(12'h000, 0, 0, 1, 0, 0, "R3 all ones read");

    // R4: high-range plain registers
    step(12'h801, 1, 32'h0001_0400, 1, 0, 0, "R4 write");
    step(12'h802, 1, 32'h89AB_CDEF, 1, 0, 0, "R4 write");
    step(12'h805, 1, 32'h0000_FFFF, 1, 0, 0, "R4 write");
    step(12'h806, 1, 32'hFFFF_0000, 1, 0, 0, "R4 write");
    step(12'h807, 1, 32'h5A5A_A5A5, 1, 0, 0, "R4 write");
    step(12'h801, 0, 0, 1, 0, 0, "R4 read");
    step(12'h802, 0, 0, 1, 0, 0, "R4 read");
    step(12'h805, 0, 0, 1, 0, 0, "R4 read");
    step(12'h806, 0, 0, 1, 0, 0, "R4 read");
    step(12'h807, 0, 0, 1, 0, 0, "R4 read");

    // R5: user stack
    step(12'h800, 1, 32'h0000_1110, 0, 0, 32'h7770, "R5 R8 live write user");
    step(12'h800, 0, 0, 0, 0, 32'h7774, "R5 live read user");
    step(12'h800, 1, 32'h0000_2220, 1, 0, 32'h7778, "R5 R8 bank write user");
    step(12'h800, 0, 0, 1, 1, 32'h777C, "R5 bank read user");

    // R6: master stack, including user mode with master set
    step(12'h803, 1, 32'h0000_3330, 1, 1, 32'h8880, "R6 R8 live write master");
    step(12'h803, 1, 32'h0000_4440, 0, 1, 32'h8884, "R6 bank write master user-mode");
    step(12'h803, 0, 0, 1, 0, 32'h8888, "R6 bank read master");
    step(12'h803, 0, 0, 1, 1, 32'h888C, "R6 live read master");

    // R7: interrupt stack
    step(12'h804, 1, 32'h0000_5550, 1, 0, 32'h9990, "R7 R8 live write intr");
    step(12'h804, 1, 32'h0000_6660, 1, 1, 32'h9994, "R7 bank write intr");
    step(12'h804, 0, 0, 0, 0, 32'h9998, "R7 bank read intr user");
    step(12'h804, 0, 0, 1, 0, 32'h999C, "R7 live read intr");

    // mode sweep without writes
    for (int sm = 0; sm < 4; sm++) begin
      step(12'h800, 0, 0, sm[1], sm[0], 32'hAB00_0000 + sm, "R5 sweep");
      step(12'h803, 0, 0, sm[1], sm[0], 32'hAB10_0000 + sm, "R6 sweep");
      step(12'h804, 0, 0, sm[1], sm[0], 32'hAB20_0000 + sm, "R7 sweep");
    end

    // R9: undecoded codes
    step(12'h00C, 1, 32'hFFFF_FFFF, 0, 0, 1, "R9 write 00C");
    step(12'h00F, 1, 32'hFFFF_FFFF, 1, 1, 1, "R9 write 00F");
    step(12'h808, 1, 32'hFFFF_FFFF, 0, 0, 1, "R9 write 808");
    step(12'h80F, 1, 32'hFFFF_FFFF, 1, 0, 1, "R9 write 80F");
    step(12'h400, 1, 32'hFFFF_FFFF, 1, 0, 1, "R9 write 400");
    step(12'hC00, 1, 32'hFFFF_FFFF, 0, 0, 1, "R9 write C00");
    step(12'h808, 0, 0, 1, 0, 1, "R9 read 808");
    step(12'hFFF, 0, 0, 1, 0, 1, "R9 read FFF");
    read_all("R9 unchanged");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule